// File: doc/BRIEF.md
# Multi-Function Interrupt Aggregator

This block merges a group of peripheral interrupt sources, such as the write-done event of a non-volatile store, into one shared interrupt line towards the processor. Each source has its own request flag and its own enable bit. The group as a whole has a shared request flag and a shared enable bit. A global interrupt enable is held here as well. The block raises a registered vector request only when every enable in the path is set, a pending enabled source exists, and the return stack has room.

When the processor accepts the interrupt, it pulses an acknowledge. Hardware then clears the shared group flag and the global enable. The per-source flags are left untouched, so the service routine reads them to find the cause and clears each one with a write-one-to-clear pulse. Flags are set whatever the state of the enables, so software can also poll them. Turning the enables on later turns an existing pending flag into a request.

Top module: `mfi_aggregator`

## Requirements
- R1: A one-cycle pulse on bit i of `src_evt` sets `src_flag[i]` and `mf_flag` at the next clock edge, whatever the values of `src_en`, `mf_en` and `glb_en`.
- R2: `irq_req` is high in a cycle only if, in the cycle before, `glb_en`, `mf_en` and `mf_flag` were all 1, `stack_full` was 0 and `irq_ack` was 0. It rises one edge after the last of these conditions is met.
- R3: A request also needs at least one bit i with both `src_flag[i]` and `src_en[i]` set. With `mf_en` at 0, or with the pending source's enable bit at 0, `irq_req` stays low.
- R4: A pulse on `irq_ack` clears `mf_flag` and `glb_en` at the next edge. The ack wins over a same-cycle write of 1 to `glb_en`. A source event in the same cycle as the ack keeps `mf_flag` at 1.
- R5: `irq_ack` leaves every `src_flag` bit unchanged. A 1 on bit i of `src_clr` clears `src_flag[i]`, and a pulse on `mf_clr` clears `mf_flag`, at the next edge.
- R6: When a source event and a software clear of the same flag arrive in one cycle, the event wins and the flag stays 1.
- R7: While `stack_full` is 1, `irq_req` stays 0. The request is kept pending and `irq_req` rises at the first edge that samples `stack_full` at 0.
- R8: A flag that was set while its enables were 0 raises `irq_req` once all the enables have been written to 1.
- R9: `irq_req` is 0 in the cycle after an `irq_ack` pulse.
- R10: After a synchronous reset, every flag, every enable and `irq_req` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | NSRC | One-cycle event pulse per source |
| src_clr | input | NSRC | Software write-one-to-clear of the source flags |
| mf_clr | input | 1 | Software clear of the shared group flag |
| src_en_we | input | 1 | Write strobe for the source enables |
| src_en_wdata | input | NSRC | New source enable value |
| mf_en_we | input | 1 | Write strobe for the group enable |
| mf_en_wdata | input | 1 | New group enable value |
| glb_en_we | input | 1 | Write strobe for the global enable |
| glb_en_wdata | input | 1 | New global enable value |
| stack_full | input | 1 | Return stack has no free entry |
| irq_ack | input | 1 | One-cycle pulse when the processor accepts the interrupt |
| src_flag | output | NSRC | Per-source request flags |
| src_en | output | NSRC | Per-source enables |
| mf_flag | output | 1 | Shared group request flag |
| mf_en | output | 1 | Shared group enable |
| glb_en | output | 1 | Global interrupt enable |
| irq_req | output | 1 | Registered vector request |

## Verification
The hardest case to reach is the collision of hardware and software on one flag: an acknowledge, a source event and a global-enable write all landing in the same clock, or an event meeting a software clear. The bench drives these inputs together in one cycle from a single task. It then reads the flags and the enable on the next cycle, and watches whether a request comes back once the enable is restored. The stack-full hold-off is reached by keeping `stack_full` high across several cycles of a pending request and then releasing it at a known edge.

// File: rtl/mfi_pkg.sv
package mfi_pkg;
  // Group-level terms that gate the vector request
  typedef struct packed {
    logic glb;
    logic mf_en;
    logic mf_flag;
    logic stack_full;
    logic ack;
  } gate_in_t;
endpackage

// File: rtl/mfi_flag_bit.sv
// Request flag: a set has priority over a clear
module mfi_flag_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/mfi_reg.sv
// Software-written register with a hardware clear that has priority over the write
module mfi_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hw_clr,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (hw_clr) q <= '0;
    else if (we)     q <= wdata;
  end
endmodule

// File: rtl/mfi_req_gate.sv
// Registered vector request from the enable chain and the source terms
module mfi_req_gate
  import mfi_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  gate_in_t        g,
  input  logic [NSRC-1:0] src_flag,
  input  logic [NSRC-1:0] src_en,
  output logic            req_o
);
  logic live_src;
  assign live_src = |(src_flag & src_en);

  always_ff @(posedge clk) begin
    if (rst) req_o <= 1'b0;
    else     req_o <= g.glb & g.mf_en & g.mf_flag & ~g.stack_full & ~g.ack & live_src;
  end
endmodule

// File: rtl/mfi_aggregator.sv
module mfi_aggregator
  import mfi_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_evt,
  input  logic [NSRC-1:0] src_clr,
  input  logic            mf_clr,
  input  logic            src_en_we,
  input  logic [NSRC-1:0] src_en_wdata,
  input  logic            mf_en_we,
  input  logic            mf_en_wdata,
  input  logic            glb_en_we,
  input  logic            glb_en_wdata,
  input  logic            stack_full,
  input  logic            irq_ack,
  output logic [NSRC-1:0] src_flag,
  output logic [NSRC-1:0] src_en,
  output logic            mf_flag,
  output logic            mf_en,
  output logic            glb_en,
  output logic            irq_req
);
  logic     any_evt;
  gate_in_t gate;

  assign any_evt = |src_evt;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    mfi_flag_bit u_flag (
      .clk  (clk),
      .rst  (rst),
      .set_i(src_evt[i]),
      .clr_i(src_clr[i]),
      .q    (src_flag[i])
    );
  end

  mfi_flag_bit u_mf_flag (
    .clk  (clk),
    .rst  (rst),
    .set_i(any_evt),
    .clr_i(irq_ack | mf_clr),
    .q    (mf_flag)
  );

  mfi_reg #(.W(NSRC)) u_src_en (
    .clk   (clk),
    .rst   (rst),
    .hw_clr(1'b0),
    .we    (src_en_we),
    .wdata (src_en_wdata),
    .q     (src_en)
  );

  mfi_reg #(.W(1)) u_mf_en (
    .clk   (clk),
    .rst   (rst),
    .hw_clr(1'b0),
    .we    (mf_en_we),
    .wdata (mf_en_wdata),
    .q     (mf_en)
  );

  mfi_reg #(.W(1)) u_glb_en (
    .clk   (clk),
    .rst   (rst),
    .hw_clr(irq_ack),
    .we    (glb_en_we),
    .wdata (glb_en_wdata),
    .q     (glb_en)
  );

  assign gate = '{glb: glb_en, mf_en: mf_en, mf_flag: mf_flag,
                  stack_full: stack_full, ack: irq_ack};

  mfi_req_gate #(.NSRC(NSRC)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .g       (gate),
    .src_flag(src_flag),
    .src_en  (src_en),
    .req_o   (irq_req)
  );
endmodule

// File: rtl/mfi_aggregator_chk.sv
module mfi_aggregator_chk #(
  parameter int NSRC = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] src_evt,
  input logic [NSRC-1:0] src_clr,
  input logic            stack_full,
  input logic            irq_ack,
  input logic [NSRC-1:0] src_flag,
  input logic [NSRC-1:0] src_en,
  input logic            mf_flag,
  input logic            mf_en,
  input logic            glb_en,
  input logic            irq_req
);
  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    // R1, R6: an event always lands in its flag
    a_r1_src_set: assert property (@(posedge clk) disable iff (rst)
      src_evt[i] |=> src_flag[i]);
  end

  a_r1_mf_set: assert property (@(posedge clk) disable iff (rst)
    (src_evt != '0) |=> mf_flag);

  a_r2_chain: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(glb_en && mf_en && mf_flag && !stack_full && !irq_ack));

  a_r3_live_src: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past((src_flag & src_en) != '0));

  a_r4_ack_clear: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && src_evt == '0) |=> (!mf_flag && !glb_en));

  a_r5_src_kept: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && src_clr == '0) |=> ((src_flag & $past(src_flag)) == $past(src_flag)));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    stack_full |=> !irq_req);

  a_r9_ack_drop: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_req);
endmodule

bind mfi_aggregator mfi_aggregator_chk #(.NSRC(NSRC)) u_chk (.*);

// File: tb/mfi_aggregator_test.sv
`timescale 1ns/1ps
module mfi_aggregator_test;
  localparam int NSRC = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_evt = '0;
  logic [NSRC-1:0] src_clr = '0;
  logic            mf_clr = 1'b0;
  logic            src_en_we = 1'b0;
  logic [NSRC-1:0] src_en_wdata = '0;
  logic            mf_en_we = 1'b0;
  logic            mf_en_wdata = 1'b0;
  logic            glb_en_we = 1'b0;
  logic            glb_en_wdata = 1'b0;
  logic            stack_full = 1'b0;
  logic            irq_ack = 1'b0;
  logic [NSRC-1:0] src_flag;
  logic [NSRC-1:0] src_en;
  logic            mf_flag;
  logic            mf_en;
  logic            glb_en;
  logic            irq_req;

  int n_checks = 0;
  int n_bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  mfi_aggregator #(.NSRC(NSRC)) uut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 5000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_bad);
      $finish;
    end
  end

  // Returns 1 ns after a rising edge: outputs hold that edge's result, inputs set here reach the next edge
  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
  endtask

  task automatic write_en(logic [NSRC-1:0] s, logic m, logic g);
    src_en_we = 1'b1; src_en_wdata = s;
    mf_en_we = 1'b1;  mf_en_wdata = m;
    glb_en_we = 1'b1; glb_en_wdata = g;
    tick();
    src_en_we = 1'b0; mf_en_we = 1'b0; glb_en_we = 1'b0;
  endtask

  task automatic pulse_evt(logic [NSRC-1:0] e);
    src_evt = e;
    tick();
    src_evt = '0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 src_flag", src_flag, 0);
    check("R10 mf_flag", mf_flag, 0);
    check("R10 enables", {src_en, mf_en, glb_en}, 0);
    check("R10 irq_req", irq_req, 0);
  endtask

  task automatic t_poll_then_enable();
    do_reset();
    pulse_evt(2'b01);
    check("R1 src_flag set with enables off", src_flag, 2'b01);
    check("R1 mf_flag set with enables off", mf_flag, 1);
    tick(2);
    check("R3 no request while disabled", irq_req, 0);
    write_en(2'b01, 1'b1, 1'b1);
    check("R8 no request in the write cycle", irq_req, 0);
    tick();
    check("R8 pending flag raises request", irq_req, 1);
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
    check("R4 ack clears mf_flag", mf_flag, 0);
    check("R4 ack clears glb_en", glb_en, 0);
    check("R9 request drops after ack", irq_req, 0);
    check("R5 ack keeps src_flag", src_flag, 2'b01);
    tick();
    check("R9 request stays low", irq_req, 0);
    src_clr = 2'b01;
    tick();
    src_clr = '0;
    check("R5 software clear of src_flag", src_flag, 0);
  endtask

  task automatic t_enable_gating();
    do_reset();
    write_en(2'b00, 1'b1, 1'b1);
    pulse_evt(2'b10);
    tick(2);
    check("R3 source enable off blocks request", irq_req, 0);
    write_en(2'b10, 1'b0, 1'b1);
    tick(2);
    check("R3 group enable off blocks request", irq_req, 0);
    mf_en_we = 1'b1; mf_en_wdata = 1'b1;
    tick();
    mf_en_we = 1'b0;
    tick();
    check("R2 full chain raises request", irq_req, 1);
    mf_clr = 1'b1;
    tick();
    mf_clr = 1'b0;
    check("R5 mf_clr clears mf_flag", mf_flag, 0);
    tick();
    check("R2 request drops without mf_flag", irq_req, 0);
  endtask

  task automatic t_clear_race();
    do_reset();
    src_evt = 2'b01; src_clr = 2'b01; mf_clr = 1'b1;
    tick();
    src_evt = '0; src_clr = '0; mf_clr = 1'b0;
    check("R6 event beats src clear", src_flag, 2'b01);
    check("R6 event beats mf clear", mf_flag, 1);
  endtask

  task automatic t_stack_hold();
    do_reset();
    write_en(2'b11, 1'b1, 1'b1);
    stack_full = 1'b1;
    pulse_evt(2'b10);
    tick(3);
    check("R7 held off while stack full", irq_req, 0);
    stack_full = 1'b0;
    tick();
    check("R7 request issued once stack frees", irq_req, 1);
  endtask

  task automatic t_ack_race();
    do_reset();
    write_en(2'b01, 1'b1, 1'b1);
    pulse_evt(2'b01);
    tick();
    check("R2 request before race", irq_req, 1);
    irq_ack = 1'b1; src_evt = 2'b01;
    glb_en_we = 1'b1; glb_en_wdata = 1'b1;
    tick();
    irq_ack = 1'b0; src_evt = '0; glb_en_we = 1'b0;
    check("R4 ack beats glb_en write", glb_en, 0);
    check("R4 event with ack keeps mf_flag", mf_flag, 1);
    check("R9 no request after ack", irq_req, 0);
    glb_en_we = 1'b1; glb_en_wdata = 1'b1;
    tick();
    glb_en_we = 1'b0;
    tick();
    check("R4 re-enable reissues request", irq_req, 1);
  endtask

  initial begin
    t_reset();
    t_poll_then_enable();
    t_enable_gating();
    t_clear_race();
    t_stack_hold();
    t_ack_race();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_bad);
    $finish;
  end
endmodule